// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block joins two 16-bit buses, A and B, with a separate storage path for each direction. The forward path takes data from bus A into a set of latches and drives bus B from them. The reverse path takes data from bus B and drives bus A. Each path has three active-low controls: a chip select, a capture gate and a drive gate. The chip select must be low before the path can take in data or drive its bus. While the chip select and the capture gate are both low, the latches follow their input. When the capture gate rises, they keep what they last sampled.

The 16-bit word is split into two 8-bit halves. Each half has its own control bit in every control vector, so the block can work as two separate byte-wide transceivers. Tying the two control bits together makes it a single 16-bit transceiver. Each bus is modelled on chip as an input word, a per-bit "externally driven" qualifier, an output word and a per-bit output enable. A bus-hold stage on each data input keeps the last driven level of any bit that nothing is driving.

Top module: `xcvr_latched`

## Requirements
- R1: While a direction's chip select and capture gate for a half are both low, that half's latch output follows its input bus in the same cycle, and the opposite bus carries it when the drive gate is also low.
- R2: After the capture gate for a half goes high with the chip select low, the latch output keeps the input value sampled at the last clock edge at which the half was transparent. Later input changes do not reach the output.
- R3: While a half's chip select is high, its latch contents do not change, whatever its capture gate does. When the chip select returns low with the capture gate high, the earlier contents appear.
- R4: For each half, the output enable of the driven bus is high on all 8 bits exactly when that direction's chip select and drive gate are both low. Otherwise the enable is low and the output data is zero.
- R5: The reverse path behaves like the forward path, with bus B as its input and bus A as its output, and uses its own three control vectors.
- R6: Half h covers bits [8h+7:8h] and is governed only by bit h of each control vector. The other half's controls never affect it.
- R7: When a data input bit's "driven" qualifier is low, the block sees the level that bit had at the last clock edge at which it was driven.
- R8: After the asynchronous reset, all latches and bus-hold stages read zero. Both bus output enables stay low until a direction's chip select and drive gate are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples latches and bus-hold stages |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ab_ce_n_i | input | 2 | A-to-B chip select per half, active low |
| ab_le_n_i | input | 2 | A-to-B capture gate per half, active low (transparent when low) |
| ab_oe_n_i | input | 2 | A-to-B drive gate per half, active low |
| ba_ce_n_i | input | 2 | B-to-A chip select per half, active low |
| ba_le_n_i | input | 2 | B-to-A capture gate per half, active low |
| ba_oe_n_i | input | 2 | B-to-A drive gate per half, active low |
| a_i | input | 16 | Level seen on bus A |
| a_drv_i | input | 16 | Per-bit flag: bus A bit driven by another source |
| b_i | input | 16 | Level seen on bus B |
| b_drv_i | input | 16 | Per-bit flag: bus B bit driven by another source |
| a_o | output | 16 | Data this block drives onto bus A |
| a_oe_o | output | 16 | Per-bit enable for driving bus A |
| b_o | output | 16 | Data this block drives onto bus B |
| b_oe_o | output | 16 | Per-bit enable for driving bus B |

## Verification
Transparency and output enables are combinational, so their results are due in the same cycle as the stimulus. The bench drives inputs one time unit after a rising edge and samples one time unit later, before the next edge. Holding after the capture gate rises, and bus-hold retention, depend on the latest clock edge. For these the bench applies the value, lets exactly one rising edge pass, then changes the control or the qualifier and changes the input data, and samples before the next edge. This shows that the output holds the value from that edge and not the new input.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned HALF_W     = 8;
  localparam int unsigned NUM_HALVES = 2;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] drv_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] hold_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign eff_o[i] = drv_i[i] ? d_i[i] : hold_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= eff_o;
  end

  // undriven bits keep their level across edges
  p_bus_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~drv_i & ~$past(drv_i) & (eff_o ^ $past(eff_o))) == '0));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W = HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  lane_ctrl_t   ctrl_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         drv_o,
  output logic [W-1:0] y_o
);
  logic         open;
  logic [W-1:0] store_q;

  assign open  = ~ctrl_i.ce_n & ~ctrl_i.le_n;
  assign q_o   = open ? d_i : store_q;
  assign drv_o = ~ctrl_i.ce_n & ~ctrl_i.oe_n;
  assign y_o   = drv_o ? q_o : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= '0;
    else if (open) store_q <= d_i;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open && !$past(open)) |-> $stable(q_o));

  p_ce_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.ce_n && $past(ctrl_i.ce_n) && !open) |-> (q_o == $past(q_o)));

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.ce_n || ctrl_i.oe_n) |-> (!drv_o && y_o == '0));

  p_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open && drv_o) |-> (y_o == d_i));
endmodule

// File: rtl/xcvr_latched.sv
module xcvr_latched
  import xcvr_pkg::*;
#(
  parameter int unsigned HW = HALF_W,
  parameter int unsigned NH = NUM_HALVES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NH-1:0]    ab_ce_n_i,
  input  logic [NH-1:0]    ab_le_n_i,
  input  logic [NH-1:0]    ab_oe_n_i,
  input  logic [NH-1:0]    ba_ce_n_i,
  input  logic [NH-1:0]    ba_le_n_i,
  input  logic [NH-1:0]    ba_oe_n_i,
  input  logic [NH*HW-1:0] a_i,
  input  logic [NH*HW-1:0] a_drv_i,
  input  logic [NH*HW-1:0] b_i,
  input  logic [NH*HW-1:0] b_drv_i,
  output logic [NH*HW-1:0] a_o,
  output logic [NH*HW-1:0] a_oe_o,
  output logic [NH*HW-1:0] b_o,
  output logic [NH*HW-1:0] b_oe_o
);
  localparam int unsigned BW = NH * HW;

  logic [BW-1:0] a_eff, b_eff;

  xcvr_bus_hold #(.W(BW)) u_hold_a (
    .clk_i, .rst_ni, .d_i(a_i), .drv_i(a_drv_i), .eff_o(a_eff)
  );
  xcvr_bus_hold #(.W(BW)) u_hold_b (
    .clk_i, .rst_ni, .d_i(b_i), .drv_i(b_drv_i), .eff_o(b_eff)
  );

  for (genvar h = 0; h < NH; h++) begin : g_half
    lane_ctrl_t    ab_ctrl, ba_ctrl;
    logic [HW-1:0] ab_q, ba_q;
    logic          ab_drv, ba_drv;

    assign ab_ctrl = '{ce_n: ab_ce_n_i[h], le_n: ab_le_n_i[h], oe_n: ab_oe_n_i[h]};
    assign ba_ctrl = '{ce_n: ba_ce_n_i[h], le_n: ba_le_n_i[h], oe_n: ba_oe_n_i[h]};

    xcvr_lane #(.W(HW)) u_ab (
      .clk_i, .rst_ni, .ctrl_i(ab_ctrl), .d_i(a_eff[h*HW +: HW]),
      .q_o(ab_q), .drv_o(ab_drv), .y_o(b_o[h*HW +: HW])
    );
    xcvr_lane #(.W(HW)) u_ba (
      .clk_i, .rst_ni, .ctrl_i(ba_ctrl), .d_i(b_eff[h*HW +: HW]),
      .q_o(ba_q), .drv_o(ba_drv), .y_o(a_o[h*HW +: HW])
    );

    assign b_oe_o[h*HW +: HW] = {HW{ab_drv}};
    assign a_oe_o[h*HW +: HW] = {HW{ba_drv}};

    // enable of a half follows only that half's controls
    p_half_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ab_ce_n_i[h] || ab_oe_n_i[h]) |-> (b_oe_o[h*HW +: HW] == '0));
  end

  // no external source may drive a bit this block is driving
  p_no_contend_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((b_oe_o & b_drv_i) == '0));
  p_no_contend_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_oe_o & a_drv_i) == '0));
endmodule

// File: tb/xcvr_latched_tb.sv
module xcvr_latched_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_ni = 0;
  logic [1:0]  ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
  logic [15:0] a_in, a_drv, b_in, b_drv;
  logic [15:0] a_out, a_oe, b_out, b_oe;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_latched u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ab_ce_n_i(ab_ce_n), .ab_le_n_i(ab_le_n), .ab_oe_n_i(ab_oe_n),
    .ba_ce_n_i(ba_ce_n), .ba_le_n_i(ba_le_n), .ba_oe_n_i(ba_oe_n),
    .a_i(a_in), .a_drv_i(a_drv), .b_i(b_in), .b_drv_i(b_drv),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic all_idle();
    ab_ce_n = 2'b11; ab_le_n = 2'b11; ab_oe_n = 2'b11;
    ba_ce_n = 2'b11; ba_le_n = 2'b11; ba_oe_n = 2'b11;
  endtask

  task automatic t_reset();
    all_idle(); a_in = '0; b_in = '0; a_drv = 16'hFFFF; b_drv = '0;
    rst_ni = 0; #(3*CLK_PERIOD); rst_ni = 1; tick();
    chk("R8 b_oe idle", b_oe, 16'h0000);
    chk("R8 a_oe idle", a_oe, 16'h0000);
    ab_ce_n = 2'b00; ab_oe_n = 2'b00; #1;
    chk("R8 A-to-B store zero", b_out, 16'h0000);
    chk("R8 b_oe on", b_oe, 16'hFFFF);
    all_idle(); #1;
  endtask

  task automatic t_transparent();
    ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
    a_in = 16'h1234; #1;
    chk("R1 follow 1234", b_out, 16'h1234);
    a_in = 16'hA5C3; #1;
    chk("R1 follow A5C3", b_out, 16'hA5C3);
    a_in = 16'h1234;
  endtask

  task automatic t_hold();
    tick();
    ab_le_n = 2'b11; a_in = 16'h5678; #1;
    chk("R2 hold after rise", b_out, 16'h1234);
    tick();
    chk("R2 hold next cycle", b_out, 16'h1234);
  endtask

  task automatic t_ce_hold();
    ab_ce_n = 2'b11; ab_le_n = 2'b00; a_in = 16'hFFFF;
    tick(); tick();
    chk("R3 released while ce high", b_oe, 16'h0000);
    ab_ce_n = 2'b00; ab_le_n = 2'b11; #1;
    chk("R3 contents kept", b_out, 16'h1234);
  endtask

  task automatic t_oe_matrix();
    ab_le_n = 2'b11;
    for (int ce = 0; ce < 4; ce++) begin
      for (int oe = 0; oe < 4; oe++) begin
        logic [15:0] en;
        ab_ce_n = ce[1:0]; ab_oe_n = oe[1:0]; #1;
        en = {{8{~ce[1] & ~oe[1]}}, {8{~ce[0] & ~oe[0]}}};
        chk("R4 b_oe", b_oe, en);
        chk("R4 b data", b_out, 16'h1234 & en);
      end
    end
  endtask

  task automatic t_halves();
    ab_ce_n = 2'b00; ab_oe_n = 2'b00; ab_le_n = 2'b10; a_in = 16'hABCD; #1;
    chk("R6 low half open", b_out, 16'h12CD);
    tick();
    ab_le_n = 2'b01; a_in = 16'hEF00; #1;
    chk("R6 high half open", b_out, 16'hEFCD);
    ab_ce_n = 2'b01; ab_oe_n = 2'b00; #1;
    chk("R6 enable per half", b_oe, 16'hFF00);
    ab_ce_n = 2'b11; ab_le_n = 2'b11; #1;
  endtask

  task automatic t_bus_hold();
    ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
    a_drv = 16'hFFFF; a_in = 16'h0F0F; tick();
    a_drv = 16'h0000; a_in = 16'hFFFF; #1;
    chk("R7 undriven keeps level", b_out, 16'h0F0F);
    tick(); tick();
    chk("R7 still kept", b_out, 16'h0F0F);
    a_drv = 16'h00FF; a_in = 16'h3355; #1;
    chk("R7 mixed drive", b_out, 16'h0F55);
    all_idle(); a_drv = 16'hFFFF; #1;
  endtask

  task automatic t_reverse();
    all_idle(); a_drv = 16'h0000; b_drv = 16'hFFFF; #1;
    ba_ce_n = 2'b00; ba_le_n = 2'b00; ba_oe_n = 2'b00;
    b_in = 16'h9ABC; #1;
    chk("R5 reverse follow", a_out, 16'h9ABC);
    chk("R5 a_oe on", a_oe, 16'hFFFF);
    chk("R5 b side idle", b_oe, 16'h0000);
    tick();
    ba_le_n = 2'b11; b_in = 16'h0000; #1;
    chk("R5 reverse hold", a_out, 16'h9ABC);
    ba_oe_n = 2'b10; #1;
    chk("R5 reverse per-half drive", a_oe, 16'h00FF);
    all_idle(); #1;
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_ce_hold();
    t_oe_matrix();
    t_halves();
    t_bus_hold();
    t_reverse();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule